// File: doc/BRIEF.md
# Power Partition Gate Controller

This block controls power to a configurable number of on-chip power partitions. Software reaches it through a small register port that has a write strobe, a byte offset and a 32-bit data word. Reads return the current power status combinationally. It drives two vectors, each with one bit per partition. The power-enable vector switches a partition's supply on or off. The isolation-clamp vector holds a partition's outputs at a safe level while that partition is not ready.

A power change is a toggle, not a set. A start command names one partition, and a sequencer then flips that partition's state after a modelled settle delay. The sequencer is a three-state machine:

- `SEQ_IDLE` waits for a valid start command.
- `SEQ_SETTLE` counts down `SETTLE_CYC` cycles.
- `SEQ_APPLY` flips the latched partition's power bit and returns to `SEQ_IDLE`.

Its transitions are:

- idle→settle when a valid start is accepted.
- settle→settle while the counter is non-zero.
- settle→apply when the counter reaches zero.
- apply→idle unconditionally.

Clamp release is a mask write. Two designated partitions, `SWAP_A` and `SWAP_B`, have their release bits cross-wired, so a request for one releases the other.

Top module: `power_gate_ctrl`

## Requirements
- R1: After reset, every power-enable bit is 0, every clamp bit is 1, busy is 0, and the status read returns 0.
- R2: A write to offset 0x30 whose bit 8 is 1 and whose bits [7:0] hold an ID below `NUM_PART` starts a toggle of that partition. Reading offset 0x38 returns the power-enable vector, with bit i set when partition i is powered.
- R3: busy rises in the cycle after an accepted start and stays high for exactly `SETTLE_CYC`+1 cycles. The addressed power bit inverts in the same cycle that busy falls, and no other power bit changes.
- R4: A write to offset 0x30 with bit 8 equal to 0 changes neither the power state nor busy.
- R5: A start that names an ID at or above `NUM_PART` is ignored, and busy stays 0.
- R6: A start written while busy is 1 is ignored: it neither flips power nor extends busy.
- R7: A write to offset 0x34 clears clamp bit i in the next cycle for each mask bit i that is 1 (i below `NUM_PART`, i not in the swapped pair). Mask bits at or above `NUM_PART` have no effect. A clamp bit is only ever released by such a write.
- R8: Mask bit `SWAP_A` releases clamp bit `SWAP_B`, and mask bit `SWAP_B` releases clamp bit `SWAP_A`.
- R9: When a partition's power bit goes from 1 to 0, its clamp bit is 1 in that same cycle. If a release arrives in that same cycle, the power-off wins.
- R10: A read at any offset other than 0x38 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| busy | output | 1 | Toggle in progress |
| pwr_en | output | NUM_PART | Power enable, one bit per partition |
| clamp | output | NUM_PART | Isolation clamp, 1 = clamped |

## Verification
The bench builds the block with `NUM_PART`=14, `SETTLE_CYC`=4, and the swapped pair at IDs 3 and 4. With 14 partitions, the highest legal ID is 13, and IDs 14 and 255 land in the ignored range. A mask bit at 20 sits beyond the partition count. The short settle window lets a second start be written well inside the busy period, and it lets the busy length be counted exactly. A scoreboard queue holds the expected power vector for every accepted toggle. Each queued entry is compared against the output when busy falls.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ID_W      = 8;
    localparam int unsigned START_BIT = 8;

    localparam logic [ADDR_W-1:0] OFF_TOGGLE = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_CLAMP  = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h38;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_APPLY  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/ppg_regif.sv
module ppg_regif
    import ppg_pkg::*;
#(
    parameter int unsigned NUM_PART = 25
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_PART-1:0] pwr_en,
    output logic                tog_req,
    output logic [ID_W-1:0]     tog_id,
    output logic                rel_req,
    output logic [NUM_PART-1:0] rel_mask,
    output logic [DATA_W-1:0]   rdata
);
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    assign tog_id   = wdata[ID_W-1:0];
    assign tog_req  = wr_en && (addr == OFF_TOGGLE) && wdata[START_BIT]
                      && (32'(tog_id) < NUM_PART);
    assign rel_req  = wr_en && (addr == OFF_CLAMP);
    assign rel_mask = wdata[NUM_PART-1:0];

    always_comb begin
        rdata = '0;
        if (addr == OFF_STATUS) rdata[NUM_PART-1:0] = pwr_en;
    end
endmodule

// File: rtl/ppg_seq.sv
module ppg_seq
    import ppg_pkg::*;
#(
    parameter int unsigned NUM_PART   = 25,
    parameter int unsigned SETTLE_CYC = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tog_req,
    input  logic [ID_W-1:0]     tog_id,
    output logic [NUM_PART-1:0] pwr_en,
    output logic                busy,
    output logic [NUM_PART-1:0] off_evt
);
    localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC - 1);

    seq_state_t state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [ID_W-1:0]     tgt_q;
    logic [NUM_PART-1:0] flip_mask;
    logic                apply;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        busy    = 1'b1;
        apply   = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                busy = 1'b0;
                if (tog_req) state_d = SEQ_SETTLE;
            end
            SEQ_SETTLE: begin
                if (cnt_q == '0) state_d = SEQ_APPLY;
            end
            SEQ_APPLY: begin
                apply   = 1'b1;
                state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tgt_q <= '0;
        end else if (state_q == SEQ_IDLE && tog_req) begin
            cnt_q <= CNT_LOAD;
            tgt_q <= tog_id;
        end else if (state_q == SEQ_SETTLE && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        flip_mask = '0;
        for (int i = 0; i < NUM_PART; i++)
            flip_mask[i] = apply && (32'(tgt_q) == i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwr_en <= '0;
        else        pwr_en <= pwr_en ^ flip_mask;
    end

    assign off_evt = flip_mask & pwr_en;
endmodule

// File: rtl/ppg_clamp.sv
module ppg_clamp #(
    parameter int unsigned NUM_PART = 25,
    parameter int unsigned SWAP_A   = 3,
    parameter int unsigned SWAP_B   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rel_req,
    input  logic [NUM_PART-1:0] rel_mask,
    input  logic [NUM_PART-1:0] off_evt,
    output logic [NUM_PART-1:0] clamp
);
    for (genvar i = 0; i < NUM_PART; i++) begin : g_bit
        localparam int unsigned SRC = (i == SWAP_A) ? SWAP_B :
                                      (i == SWAP_B) ? SWAP_A : i;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        clamp[i] <= 1'b1;
            else if (off_evt[i])               clamp[i] <= 1'b1;
            else if (rel_req && rel_mask[SRC]) clamp[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/power_gate_ctrl.sv
module power_gate_ctrl
    import ppg_pkg::*;
#(
    parameter int unsigned NUM_PART   = 25,
    parameter int unsigned SETTLE_CYC = 8,
    parameter int unsigned SWAP_A     = 3,
    parameter int unsigned SWAP_B     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    output logic                busy,
    output logic [NUM_PART-1:0] pwr_en,
    output logic [NUM_PART-1:0] clamp
);
    logic                tog_req, rel_req;
    logic [ID_W-1:0]     tog_id;
    logic [NUM_PART-1:0] rel_mask, off_evt;

    ppg_regif #(.NUM_PART(NUM_PART)) i_regif (
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .pwr_en(pwr_en),
        .tog_req(tog_req), .tog_id(tog_id), .rel_req(rel_req),
        .rel_mask(rel_mask), .rdata(rdata)
    );

    ppg_seq #(.NUM_PART(NUM_PART), .SETTLE_CYC(SETTLE_CYC)) i_seq (
        .clk(clk), .rst_n(rst_n), .tog_req(tog_req), .tog_id(tog_id),
        .pwr_en(pwr_en), .busy(busy), .off_evt(off_evt)
    );

    ppg_clamp #(.NUM_PART(NUM_PART), .SWAP_A(SWAP_A), .SWAP_B(SWAP_B)) i_clamp (
        .clk(clk), .rst_n(rst_n), .rel_req(rel_req), .rel_mask(rel_mask),
        .off_evt(off_evt), .clamp(clamp)
    );
endmodule

// File: rtl/power_gate_ctrl_chk.sv
module power_gate_ctrl_chk #(
    parameter int unsigned NUM_PART   = 25,
    parameter int unsigned SETTLE_CYC = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [7:0]          addr,
    input logic                start_bit,
    input logic                busy,
    input logic [NUM_PART-1:0] pwr_en,
    input logic [NUM_PART-1:0] clamp
);
    logic [31:0] busy_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= '0;
    end

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len == SETTLE_CYC + 1);

    // R3
    one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $countones(pwr_en ^ $past(pwr_en)) == 1);

    // R3
    pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(pwr_en));

    // R2
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && addr == 8'h30 && start_bit));

    // R9
    off_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pwr_en) & ~pwr_en & ~clamp) == '0));

    // R7
    release_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(clamp) & ~clamp)) |-> $past(wr_en && addr == 8'h34));
endmodule

bind power_gate_ctrl power_gate_ctrl_chk #(
    .NUM_PART(NUM_PART), .SETTLE_CYC(SETTLE_CYC)
) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .start_bit(wdata[8]), .busy(busy), .pwr_en(pwr_en), .clamp(clamp)
);

// File: tb/test_power_gate_ctrl.sv
module test_power_gate_ctrl;
    localparam int N = 14;
    localparam int S = 4;
    localparam int SA = 3;
    localparam int SB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          busy;
    logic [N-1:0]  pwr_en, clamp;

    int n_chk = 0, n_fail = 0;
    logic [N-1:0] m_pwr = '0;
    logic [N-1:0] m_clamp = '1;
    logic [N-1:0] exp_q[$];
    bit done = 0;

    always #5 clk = ~clk;

    power_gate_ctrl #(.NUM_PART(N), .SETTLE_CYC(S), .SWAP_A(SA), .SWAP_B(SB)) i_power_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .busy(busy), .pwr_en(pwr_en), .clamp(clamp)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h38; wdata = '0;
    endtask

    task automatic toggle(input int id);
        m_pwr[id] = ~m_pwr[id];
        if (!m_pwr[id]) m_clamp[id] = 1'b1;
        exp_q.push_back(m_pwr);
        wr(8'h30, 32'h100 | id);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // monitor: pop expected vector when a toggle completes
    int  blen = 0;
    bit  prev_busy = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_busy && !busy) begin
                check(blen == S + 1, "R3 busy length", blen, S + 1);
                if (exp_q.size() == 0) check(0, "R3 unexpected toggle", {18'b0, pwr_en}, '0);
                else begin
                    logic [N-1:0] e;
                    e = exp_q.pop_front();
                    check(pwr_en == e, "R2 power after toggle", {18'b0, pwr_en}, {18'b0, e});
                end
                blen = 0;
            end
            if (busy) blen++;
            prev_busy = busy;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        addr = 8'h38;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(pwr_en == '0, "R1 power", {18'b0, pwr_en}, '0);
        check(clamp == '1, "R1 clamp", {18'b0, clamp}, {18'b0, {N{1'b1}}});
        check(busy == 1'b0, "R1 busy", {31'b0, busy}, '0);
        check(rdata == '0, "R1 status", rdata, '0);

        // R2 basic toggles incl. top ID
        toggle(2); wait_idle();
        check(rdata == 32'h4, "R2 status read", rdata, 32'h4);
        toggle(N - 1); wait_idle();
        check(rdata == {18'b0, m_pwr}, "R2 status read top ID", rdata, {18'b0, m_pwr});

        // R7 release clamp 2
        wr(8'h34, 32'h4); m_clamp[2] = 1'b0;
        check(clamp == m_clamp, "R7 release", {18'b0, clamp}, {18'b0, m_clamp});

        // R9 power-off re-clamps
        toggle(2); wait_idle();
        check(clamp == m_clamp, "R9 reclamp on off", {18'b0, clamp}, {18'b0, m_clamp});

        // R4 start bit clear
        wr(8'h30, 32'h5);
        check(busy == 1'b0, "R4 no busy", {31'b0, busy}, '0);
        repeat (S + 3) @(negedge clk);
        check(pwr_en == m_pwr, "R4 power unchanged", {18'b0, pwr_en}, {18'b0, m_pwr});

        // R5 out of range IDs
        wr(8'h30, 32'h100 | N);
        check(busy == 1'b0, "R5 id=N no busy", {31'b0, busy}, '0);
        wr(8'h30, 32'h1FF);
        check(busy == 1'b0, "R5 id=255 no busy", {31'b0, busy}, '0);
        repeat (S + 3) @(negedge clk);
        check(pwr_en == m_pwr, "R5 power unchanged", {18'b0, pwr_en}, {18'b0, m_pwr});

        // R6 start during busy
        toggle(5);
        wr(8'h30, 32'h106);
        wait_idle();
        repeat (S + 3) @(negedge clk);
        check(busy == 1'b0, "R6 no second busy", {31'b0, busy}, '0);
        check(pwr_en == m_pwr, "R6 only first toggle", {18'b0, pwr_en}, {18'b0, m_pwr});

        // R8 swapped pair
        wr(8'h34, 32'h1 << SA); m_clamp[SB] = 1'b0;
        check(clamp == m_clamp, "R8 mask A releases B", {18'b0, clamp}, {18'b0, m_clamp});
        wr(8'h34, 32'h1 << SB); m_clamp[SA] = 1'b0;
        check(clamp == m_clamp, "R8 mask B releases A", {18'b0, clamp}, {18'b0, m_clamp});

        // R7 mask bit beyond partition count
        wr(8'h34, 32'h1 << 20);
        check(clamp == m_clamp, "R7 high mask bit ignored", {18'b0, clamp}, {18'b0, m_clamp});

        // R10 other offsets read zero
        @(negedge clk); addr = 8'h00; #1;
        check(rdata == '0, "R10 read 0x00", rdata, '0);
        addr = 8'h30; #1;
        check(rdata == '0, "R10 read 0x30", rdata, '0);
        addr = 8'h38;

        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), '0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule